// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Line Maintenance Commands

This block sits between a CPU load/store port and a memory port that moves whole 32-byte lines. It is a 16 KB direct-mapped, write-back cache. Ordinary loads and stores hit in a single cycle. A miss writes back a dirty victim if there is one and then refills the line. Dirty data is only written back on eviction or on request.

Besides loads and stores, the CPU can issue per-line commands that software uses to manage the cache around DMA buffers and streaming loops:
- prefetch a line;
- copy a dirty line out while keeping it cached;
- drop a line without writing it back;
- write a line back and drop it;
- claim a line for a new address without reading memory and store one word into it.

A configuration input turns the upper half of the data array into an 8 KB directly addressed scratchpad. The cache then runs with the lower 8 KB only.

The CPU presents a request with `req_valid` and holds it steady. The block raises `req_ready` in the cycle the request completes, and load data is valid in that same cycle. The memory side uses the same convention: a request is held until `mem_ready`, and read data is valid in the cycle `mem_ready` is high.

Top module: `dcache_maint`

## Requirements
- R1: The cache holds 16 KB in 32-byte lines, direct mapped. With scratchpad mode off, address bits [13:5] pick the line and bits [31:13] form the stored tag, so addresses 16 KB apart share a line. A load (op 0) or store (op 1) that hits raises `req_ready` in the cycle it is presented. A load returns the word picked by bits [4:2].
- R2: A load, store or prefetch that misses a clean or invalid line issues exactly one memory line read at the request address with bits [4:0] cleared, and no write. The access completes in the cycle after the read is acknowledged. A store merges its word into the fetched line and marks the line dirty.
- R3: A load, store or prefetch miss whose line holds valid dirty data first writes the old contents to the old line address, then refills. Memory finally holds the last stored data of every line that was written back.
- R4: Prefetch (op 2) on a miss loads the line and returns no data. A prefetch that hits causes no memory traffic.
- R5: Write back (op 3) on a dirty hit performs one line write. The line then stays valid and clean: a later load hits, and a later eviction of that line writes nothing.
- R6: Invalidate (op 4) completes in the cycle it is presented, with no memory traffic. A hit line becomes invalid and its dirty data is discarded, so a later load reads memory.
- R7: Purge (op 5) on a dirty hit writes the line back once and then invalidates it. On a clean hit it invalidates the line without memory traffic.
- R8: Allocate (op 6) never reads memory. If the line holds dirty data of another address, that data is written back first. The line then takes the new tag, becomes valid and dirty, and receives the 32-bit store. Its other words keep whatever the array held before.
- R9: Write back or purge that misses the tag or finds the line invalid, write back of a clean line, and the unused op 7 all complete in the cycle they are presented, with no memory traffic and no state change.
- R10: With `spm_en` high, addresses whose bits [31:13] equal `SPM_BASE`[31:13] (default 0x7C000000) form an 8 KB RAM. Loads and stores there complete in the cycle presented, with no memory traffic, and read back the last stored word. In this mode the cache index is bits [12:5] only, so cached addresses 8 KB apart conflict.
- R11: With `spm_en` high, ops 2 to 7 aimed at the scratchpad window complete at once and change neither the scratchpad contents nor memory.
- R12: After reset there is no memory request and no completion. A memory request keeps its valid, direction, address and write data steady until `mem_ready`. The CPU holds a request steady until `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spm_en | input | 1 | Scratchpad mode: upper half of the array becomes RAM; change only while idle and across a reset |
| req_valid | input | 1 | CPU request present |
| req_op | input | 3 | 0 load, 1 store, 2 prefetch, 3 write back, 4 invalidate, 5 purge, 6 allocate |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Store data for ops 1 and 6 |
| req_ready | output | 1 | Request completes this cycle |
| rsp_rdata | output | 32 | Load data, valid with `req_ready` |
| mem_valid | output | 1 | Memory line request |
| mem_we | output | 1 | 1 line write, 0 line read |
| mem_addr | output | 32 | Line byte address, bits [4:0] zero |
| mem_wdata | output | 256 | Line written back |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 256 | Line read, valid with `mem_ready` |

## Verification
A wrong tag, valid or dirty bit inside the block shows up at the ports as a memory transaction that should not happen, or one that is missing, within the same command. Examples are a write of a line that was invalidated, a read caused by an allocate, or a hit that waits for memory. A wrong word in the data array, or write-back data sent to the wrong line address, only appears later: when that line is loaded again after refill, or when memory is compared at the end of the run. For that reason, stores are followed by conflicting loads that force evictions soon after. Scratchpad corruption appears on the next load of that window word, which in scratchpad mode completes in one cycle.

// File: rtl/cm_pkg.sv
`timescale 1ns/1ps
package cm_pkg;
  localparam int ADDR_W      = 32;
  localparam int WORD_W      = 32;
  localparam int LINE_BYTES  = 32;
  localparam int CACHE_BYTES = 16 * 1024;
  localparam int OP_W        = 3;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int WPL    = LINE_BYTES * 8 / WORD_W;
  localparam int WSEL_W = $clog2(WPL);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int NLINES = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W  = $clog2(NLINES);
  // stored tag keeps the top index bit too, so one tag format serves both modes
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W + 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LINE_W-1:0] line_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [WSEL_W-1:0] wsel_t;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_PREF  = 3'd2,
    OP_WBACK = 3'd3,
    OP_INVAL = 3'd4,
    OP_PURGE = 3'd5,
    OP_ALLOC = 3'd6,
    OP_NONE  = 3'd7
  } op_e;

  // cached line index; top bit forced low when half the array is scratchpad
  function automatic idx_t line_index(input addr_t a, input logic spm);
    idx_t i;
    i = a[OFF_W +: IDX_W];
    if (spm) i[IDX_W-1] = 1'b0;
    return i;
  endfunction

  // scratchpad words live in the upper half of the array
  function automatic idx_t spm_index(input addr_t a);
    idx_t i;
    i = a[OFF_W +: IDX_W];
    i[IDX_W-1] = 1'b1;
    return i;
  endfunction

  function automatic tag_t line_tag(input addr_t a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic in_window(input addr_t a, input addr_t base);
    return a[ADDR_W-1 -: TAG_W] == base[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic wsel_t word_sel(input addr_t a);
    return a[BOFF_W +: WSEL_W];
  endfunction

  function automatic addr_t line_base(input tag_t t, input idx_t i);
    return {t, i[IDX_W-2:0], {OFF_W{1'b0}}};
  endfunction

  function automatic word_t get_word(input line_t l, input wsel_t s);
    return l[s*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/cm_tag_store.sv
`timescale 1ns/1ps
module cm_tag_store
  import cm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  idx_t rd_idx,
  output tag_t rd_tag,
  output logic rd_valid,
  output logic rd_dirty,
  input  logic wr_en,
  input  idx_t wr_idx,
  input  tag_t wr_tag,
  input  logic wr_valid,
  input  logic wr_dirty
);
  logic [NLINES-1:0] valid_q;
  logic [NLINES-1:0] dirty_q;
  tag_t              tag_q [NLINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
endmodule

// File: rtl/cm_line_store.sv
`timescale 1ns/1ps
module cm_line_store
  import cm_pkg::*;
(
  input  logic  clk,
  input  idx_t  idx,
  output line_t rd_line,
  input  logic  line_we,
  input  line_t wr_line,
  input  logic  word_we,
  input  wsel_t wr_sel,
  input  word_t wr_word
);
  // one bank per word position so a single store touches one bank only
  for (genvar w = 0; w < WPL; w++) begin : g_bank
    word_t bank_q [NLINES];
    logic  bank_we;
    word_t bank_d;

    assign bank_we = line_we || (word_we && (wr_sel == wsel_t'(w)));
    assign bank_d  = line_we ? wr_line[w*WORD_W +: WORD_W] : wr_word;

    always_ff @(posedge clk) begin
      if (bank_we) bank_q[idx] <= bank_d;
    end

    assign rd_line[w*WORD_W +: WORD_W] = bank_q[idx];
  end
endmodule

// File: rtl/cm_seq.sv
`timescale 1ns/1ps
module cm_seq
  import cm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  op_e  op,
  input  logic in_spm,
  input  logic hit,
  input  logic line_dirty,
  input  logic mem_ready,
  output logic req_ready,
  output logic mem_valid,
  output logic mem_we,
  output logic word_we,
  output logic fill_we,
  output logic tag_we,
  output logic tag_keep,
  output logic new_valid,
  output logic new_dirty
);
  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_e;
  st_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  // Every memory transfer returns to idle; the held request is then
  // re-decoded against the updated tag state.
  always_comb begin
    st_d      = st_q;
    req_ready = 1'b0;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    word_we   = 1'b0;
    fill_we   = 1'b0;
    tag_we    = 1'b0;
    tag_keep  = 1'b0;
    new_valid = 1'b0;
    new_dirty = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        if (in_spm) begin
          req_ready = 1'b1;
          word_we   = (op == OP_STORE);
        end else begin
          case (op)
            OP_LOAD, OP_STORE, OP_PREF: begin
              if (hit) begin
                req_ready = 1'b1;
                if (op == OP_STORE) begin
                  word_we   = 1'b1;
                  tag_we    = 1'b1;
                  new_valid = 1'b1;
                  new_dirty = 1'b1;
                end
              end else if (line_dirty) st_d = S_WB;
              else                     st_d = S_FILL;
            end
            OP_WBACK: begin
              if (hit && line_dirty) st_d = S_WB;
              else                   req_ready = 1'b1;
            end
            OP_INVAL: begin
              req_ready = 1'b1;
              tag_we    = hit;
            end
            OP_PURGE: begin
              if (hit && line_dirty) st_d = S_WB;
              else begin
                req_ready = 1'b1;
                tag_we    = hit;
              end
            end
            OP_ALLOC: begin
              if (!hit && line_dirty) st_d = S_WB;
              else begin
                req_ready = 1'b1;
                word_we   = 1'b1;
                tag_we    = 1'b1;
                new_valid = 1'b1;
                new_dirty = 1'b1;
              end
            end
            default: req_ready = 1'b1;
          endcase
        end
      end
      S_WB: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        if (mem_ready) begin
          tag_we    = 1'b1;
          tag_keep  = 1'b1;
          new_valid = 1'b1;
          st_d      = S_IDLE;
        end
      end
      S_FILL: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          fill_we   = 1'b1;
          tag_we    = 1'b1;
          new_valid = 1'b1;
          st_d      = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end
endmodule

// File: rtl/dcache_maint.sv
`timescale 1ns/1ps
module dcache_maint
  import cm_pkg::*;
#(
  parameter logic [31:0] SPM_BASE = 32'h7C00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spm_en,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rdata
);
  op_e   op;
  logic  spm_hit;
  idx_t  idx;
  tag_t  req_tag;
  wsel_t wsel;

  assign op      = op_e'(req_op);
  assign spm_hit = spm_en && in_window(req_addr, SPM_BASE);
  assign idx     = spm_hit ? spm_index(req_addr) : line_index(req_addr, spm_en);
  assign req_tag = line_tag(req_addr);
  assign wsel    = word_sel(req_addr);

  tag_t  st_tag;
  logic  st_valid, st_dirty;
  logic  line_hit, line_dirty;
  line_t rd_line;

  logic word_we, fill_we, tag_we, tag_keep, new_valid, new_dirty;

  // named events for the checker
  logic fill_done, wb_done;

  assign line_hit   = st_valid && (st_tag == req_tag);
  assign line_dirty = st_valid && st_dirty;
  assign fill_done  = mem_valid && !mem_we && mem_ready;
  assign wb_done    = mem_valid && mem_we && mem_ready;

  cm_tag_store u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (idx),
    .rd_tag   (st_tag),
    .rd_valid (st_valid),
    .rd_dirty (st_dirty),
    .wr_en    (tag_we),
    .wr_idx   (idx),
    .wr_tag   (tag_keep ? st_tag : req_tag),
    .wr_valid (new_valid),
    .wr_dirty (new_dirty)
  );

  cm_line_store u_lines (
    .clk     (clk),
    .idx     (idx),
    .rd_line (rd_line),
    .line_we (fill_we),
    .wr_line (mem_rdata),
    .word_we (word_we),
    .wr_sel  (wsel),
    .wr_word (req_wdata)
  );

  cm_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .op         (op),
    .in_spm     (spm_hit),
    .hit        (line_hit),
    .line_dirty (line_dirty),
    .mem_ready  (mem_ready),
    .req_ready  (req_ready),
    .mem_valid  (mem_valid),
    .mem_we     (mem_we),
    .word_we    (word_we),
    .fill_we    (fill_we),
    .tag_we     (tag_we),
    .tag_keep   (tag_keep),
    .new_valid  (new_valid),
    .new_dirty  (new_dirty)
  );

  assign rsp_rdata = get_word(rd_line, wsel);
  assign mem_wdata = rd_line;
  assign mem_addr  = mem_we ? line_base(st_tag, idx)
                            : {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/cm_checker.sv
`timescale 1ns/1ps
module cm_checker
  import cm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [OP_W-1:0]   req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LINE_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              spm_hit,
  input logic              line_valid,
  input logic              line_dirty,
  input logic              fill_done,
  input logic              wb_done
);
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr)
                                && $stable(mem_wdata));

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr));

  a_r2_fill_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> req_ready);

  a_r3_wb_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> line_dirty);

  a_r5_wb_keeps_line: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> line_valid && !line_dirty);

  a_r6_inval_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_op == OP_INVAL) |-> req_ready && !mem_valid);

  a_r8_alloc_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we |-> (req_op != OP_ALLOC) && (req_op != OP_PURGE)
                             && (req_op != OP_WBACK));

  a_r10_spm_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && spm_hit |-> req_ready && !mem_valid);
endmodule

bind dcache_maint cm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_addr   (req_addr),
  .req_ready  (req_ready),
  .mem_valid  (mem_valid),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready),
  .spm_hit    (spm_hit),
  .line_valid (st_valid),
  .line_dirty (line_dirty),
  .fill_done  (fill_done),
  .wb_done    (wb_done)
);

// File: tb/sim_dcache_maint.sv
`timescale 1ns/1ps
module sim_dcache_maint;
  localparam logic [31:0] SPMB = 32'h7C00_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         spm_en = 1'b0;
  logic         req_valid = 1'b0;
  logic [2:0]   req_op = '0;
  logic [31:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         req_ready;
  logic [31:0]  rsp_rdata;
  logic         mem_valid, mem_we;
  logic [31:0]  mem_addr;
  logic [255:0] mem_wdata;
  logic         mem_ready = 1'b0;
  logic [255:0] mem_rdata = '0;

  always #2 clk = ~clk;

  dcache_maint #(.SPM_BASE(SPMB)) u0 (.*);

  int checks = 0, fails = 0, cycles = 0;
  int nrd = 0, nwr = 0, lat = -1;
  bit phase_spm = 0;

  logic [255:0] bmem [logic [26:0]];
  logic [255:0] rmem [logic [26:0]];

  bit           r_valid [512];
  bit           r_dirty [512];
  logic [18:0]  r_tag   [512];
  logic [255:0] r_line  [512];
  logic [7:0]   r_known [512];

  function automatic logic [255:0] init_line(input logic [26:0] la);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = ({5'd0, la} * 32'h9E37) ^ (w << 28) ^ 32'hA5A5_0000;
    return l;
  endfunction

  function automatic logic [255:0] rget(input logic [26:0] la);
    return rmem.exists(la) ? rmem[la] : init_line(la);
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // memory model: fixed-seed random latency of 0..2 extra cycles
  always @(negedge clk) begin
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_valid) begin
      if (lat < 0) lat = $urandom % 3;
      if (lat == 0) begin
        if (mem_we) begin
          bmem[mem_addr[31:5]] = mem_wdata;
          nwr++;
        end else begin
          mem_rdata = bmem.exists(mem_addr[31:5]) ? bmem[mem_addr[31:5]]
                                                  : init_line(mem_addr[31:5]);
          nrd++;
        end
        mem_ready = 1'b1;
        lat = -1;
      end else lat--;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "R12", "watchdog expired", cycles, 150000);
      summary();
      $finish;
    end
  end

  task automatic do_reset(input bit spm);
    @(negedge clk);
    rst_n = 1'b0;
    spm_en = spm;
    phase_spm = spm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 512; i++) begin r_valid[i] = 0; r_dirty[i] = 0; end
    @(negedge clk); #1;
    chk(!mem_valid && !req_ready, "R12", "idle after reset", {mem_valid, req_ready}, 0);
  endtask

  task automatic evict(input int i);
    rmem[{r_tag[i], i[7:0]}] = r_line[i];
    r_dirty[i] = 0;
  endtask

  task automatic refill(input int i, input logic [31:0] a);
    r_line[i] = rget(a[31:5]);
    r_known[i] = 8'hFF;
    r_valid[i] = 1; r_dirty[i] = 0; r_tag[i] = a[31:13];
  endtask

  task automatic ref_apply(input int op, input logic [31:0] a, input logic [31:0] d,
                           output logic [31:0] er, output bit ek,
                           output int enr, output int enw, output string rq);
    int i, w;
    bit hit, dty;
    enr = 0; enw = 0; er = '0; ek = 0;
    w = (a >> 2) & 7;
    if (phase_spm && a[31:13] == SPMB[31:13]) begin
      i = 256 + ((a >> 5) & 255);
      if (op == 1) begin r_line[i][w*32 +: 32] = d; r_known[i][w] = 1; end
      if (op == 0) begin er = r_line[i][w*32 +: 32]; ek = r_known[i][w]; end
      rq = (op <= 1) ? "R10" : "R11";
      return;
    end
    i = phase_spm ? ((a >> 5) & 255) : ((a >> 5) & 511);
    hit = r_valid[i] && r_tag[i] == a[31:13];
    dty = r_valid[i] && r_dirty[i];
    case (op)
      0, 1, 2: begin
        if (!hit) begin
          if (dty) begin evict(i); enw++; end
          refill(i, a); enr++;
        end
        if (op == 0) begin er = r_line[i][w*32 +: 32]; ek = r_known[i][w]; end
        if (op == 1) begin r_line[i][w*32 +: 32] = d; r_known[i][w] = 1; r_dirty[i] = 1; end
        rq = (op == 2) ? "R4" : (enw != 0) ? "R3" : (enr != 0) ? "R2" : "R1";
      end
      3: begin
        if (hit && dty) begin evict(i); enw++; rq = "R5"; end else rq = "R9";
      end
      4: begin
        if (hit) r_valid[i] = 0;
        rq = "R6";
      end
      5: begin
        if (hit) begin
          if (dty) begin evict(i); enw++; end
          r_valid[i] = 0;
          rq = "R7";
        end else rq = "R9";
      end
      6: begin
        if (!hit && dty) begin evict(i); enw++; end
        r_tag[i] = a[31:13]; r_valid[i] = 1; r_dirty[i] = 1;
        r_line[i][w*32 +: 32] = d; r_known[i][w] = 1;
        rq = "R8";
      end
      default: rq = "R9";
    endcase
  endtask

  task automatic cpu_op(input int op, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op[2:0]; req_addr = a; req_wdata = d;
    cyc = 0;
    forever begin
      #1;
      cyc++;
      if (req_ready) break;
      if (cyc > 500) break;
      @(negedge clk);
    end
    rd = rsp_rdata;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic run(input int op, input logic [31:0] a, input logic [31:0] d);
    logic [31:0] er, rd;
    bit ek;
    int enr, enw, cyc, rd0, wr0;
    string rq;
    rd0 = nrd; wr0 = nwr;
    ref_apply(op, a, d, er, ek, enr, enw, rq);
    cpu_op(op, a, d, rd, cyc);
    if (cyc > 500) begin
      chk(0, rq, "request never completed", cyc, 0);
      return;
    end
    chk(nrd - rd0 == enr, rq, "line reads", nrd - rd0, enr);
    chk(nwr - wr0 == enw, rq, "line writes", nwr - wr0, enw);
    if (enr == 0 && enw == 0) chk(cyc == 1, rq, "single-cycle completion", cyc, 1);
    if (op == 0 && ek) chk(rd === er, rq, "load data", rd, er);
  endtask

  function automatic logic [31:0] rnd_addr();
    if (phase_spm && ($urandom % 4) == 0) return SPMB + (($urandom % 2048) << 2);
    return 32'h1000_0000 + ($urandom % 4) * (phase_spm ? 8192 : 16384)
         + (($urandom % 8) << 5) + (($urandom % 8) << 2);
  endfunction

  task automatic random_ops(input int n);
    int ops [12] = '{0, 0, 0, 1, 1, 1, 2, 3, 4, 5, 6, 7};
    for (int k = 0; k < n; k++) run(ops[$urandom % 12], rnd_addr(), $urandom);
  endtask

  localparam logic [31:0] A = 32'h2000_0040;
  localparam logic [31:0] B = A + 32'd16384;

  initial begin
    void'($urandom(32'd1234));
    do_reset(0);
    // R1 / R3: 16 KB conflict, victim written back, reloaded data
    run(1, A, 32'h1111_0001);
    run(0, B, 0);
    run(0, A, 0);
    // R6: invalidate drops dirty data
    run(1, A, 32'h2222_0002);
    run(4, A, 0);
    run(0, A, 0);
    // R8: allocate keeps stale words of the previous line
    run(6, B, 32'h3333_0003);
    run(0, B + 4, 0);
    run(0, B, 0);
    run(0, A, 0);
    // R5: write back keeps the line valid and clean
    run(1, A, 32'h4444_0004);
    run(3, A, 0);
    run(0, A, 0);
    run(0, B, 0);
    // R7 / R9: purge then maintenance on a missing line
    run(1, A, 32'h5555_0005);
    run(5, A, 0);
    run(5, A, 0);
    run(3, A, 0);
    // R4: prefetch miss then hit
    run(2, A + 32'h100, 0);
    run(2, A + 32'h100, 0);
    run(0, A + 32'h104, 0);
    run(7, A, 0);
    random_ops(400);

    do_reset(1);
    // R10 / R11: scratchpad window and 8 KB conflicts
    run(1, SPMB + 32'h100, 32'h6666_0006);
    run(0, SPMB + 32'h100, 0);
    run(4, SPMB + 32'h100, 0);
    run(5, SPMB + 32'h100, 0);
    run(0, SPMB + 32'h100, 0);
    run(1, A, 32'h7777_0007);
    run(0, A + 32'd8192, 0);
    run(0, A, 0);
    random_ops(400);

    // R3: memory holds every written-back line
    foreach (rmem[k]) chk(bmem.exists(k) && bmem[k] === rmem[k], "R3", "memory line",
                          bmem.exists(k) ? bmem[k][31:0] : 32'hx, rmem[k][31:0]);
    foreach (bmem[k]) chk(rmem.exists(k), "R3", "unexpected line write", {5'd0, k}, 0);
    summary();
    $finish;
  end
endmodule